// File: doc/BRIEF.md
# Endpoint IN Abort Sequencer

This block cancels IN data that is still queued on one endpoint. When software requests an abort, the sequencer first masks the endpoint's transmit-ready interrupt so that no new fill is started. It then looks at how many banks are still busy. For each busy bank it fires a one-cycle kill strobe, which discards the bank written most recently, and waits for the bank logic to report that the kill has finished. When the busy count reads zero, the sequencer emits a single-cycle done pulse and returns to idle.

The bank storage and the kill mechanism are outside this block. The sequencer only sees the busy-bank count and a kill-complete pulse. The transmit-ready interrupt enable lives here as a register. A set strobe turns it on, and an accepted abort turns it off.

Top module: `ep_in_abort`

## Requirements
- R1: After synchronous reset, `tx_irq_en` is 1, `kill_stb` is 0, `abort_done` is 0, and the sequencer is idle.
- R2: An abort request that is accepted in idle drives `tx_irq_en` to 0 on the same clock edge that accepts it.
- R3: If `busy_banks` is zero one edge after acceptance, `abort_done` is high for exactly the following cycle, and no kill strobe is issued. From the request cycle to the done cycle is two edges.
- R4: If `busy_banks` is non-zero when it is evaluated, `kill_stb` is high for exactly one cycle and `abort_done` stays low.
- R5: After a kill strobe, neither another kill nor done occurs until `kill_done` is sampled high. On the edge that samples it, the sequencer goes back to evaluating `busy_banks`, and that evaluation happens on the next edge.
- R6: The number of kill strobes in one sequence equals the number of banks removed before the count reaches zero. Exactly one done pulse ends the sequence, and the block then accepts a new request.
- R7: `abort_req` has no effect while a sequence is running.
- R8: `irq_en_set` sets `tx_irq_en` to 1 on the next edge only while idle. It is ignored while a sequence runs. When it coincides with an accepted abort, the abort wins and the enable goes to 0.
- R9: `kill_done` has no effect outside the wait-for-kill phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort_req | input | 1 | Request to abort pending IN data |
| irq_en_set | input | 1 | Strobe that sets the transmit-ready interrupt enable |
| busy_banks | input | CNT_W | Number of banks still holding data to send |
| kill_done | input | 1 | Pulse from the bank logic: the last kill has finished |
| kill_stb | output | 1 | One-cycle command to discard the most recently written bank |
| tx_irq_en | output | 1 | Transmit-ready interrupt enable |
| abort_done | output | 1 | One-cycle pulse: no busy banks remain |

## Verification
Two things can arrive on the same edge: a software set of the interrupt enable and the acceptance of an abort, which clears that enable. The bench drives `irq_en_set` and `abort_req` together in one idle cycle and expects `tx_irq_en` to read 0 afterwards. The bench also drives `irq_en_set` and `abort_req` during the wait phase, and `kill_done` in idle. In each of these cases it expects no change in the enable, no extra kill and no extra done pulse.

// File: rtl/ep_abort_pkg.sv
package ep_abort_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } abort_st_t;

endpackage

// File: rtl/ep_abort_fsm.sv
module ep_abort_fsm
  import ep_abort_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_req,
  input  logic [CNT_W-1:0] busy_banks,
  input  logic             kill_done,
  output logic             accept,
  output logic             running,
  output logic             kill_stb,
  output logic             done_stb
);

  abort_st_t st;
  logic      none_busy;

  assign none_busy = (busy_banks == '0);
  assign accept    = (st == ST_IDLE) && abort_req;
  assign running   = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kill_stb <= 1'b0;
      done_stb <= 1'b0;
    end else begin
      kill_stb <= 1'b0;
      done_stb <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (abort_req) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (none_busy) begin
            done_stb <= 1'b1;
            st       <= ST_IDLE;
          end else begin
            kill_stb <= 1'b1;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (kill_done) st <= ST_CHECK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_KILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    kill_stb |=> !kill_stb);  // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_stb |=> (!done_stb && st == ST_IDLE));  // R6
  AST_KILL_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
    kill_stb |-> !done_stb);  // R3
  AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !kill_done) |=> (st == ST_WAIT && !kill_stb && !done_stb));  // R5
  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && abort_req && !kill_done) |=> (st == ST_WAIT));  // R7
  AST_ACK_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !abort_req && kill_done) |=> (st == ST_IDLE && !kill_stb));  // R9

endmodule

// File: rtl/ep_abort_irqmask.sv
module ep_abort_irqmask (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic running,
  input  logic set_req,
  output logic en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b1;
    end else if (accept) begin
      en <= 1'b0;
    end else if (set_req && !running) begin
      en <= 1'b1;
    end
  end

  AST_MASK_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> !en);  // R2
  AST_HOLD_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    running |=> $stable(en));  // R8

endmodule

// File: rtl/ep_in_abort.sv
module ep_in_abort #(
  parameter int MAX_BANKS = 7,
  localparam int CNT_W = $clog2(MAX_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort_req,
  input  logic             irq_en_set,
  input  logic [CNT_W-1:0] busy_banks,
  input  logic             kill_done,
  output logic             kill_stb,
  output logic             tx_irq_en,
  output logic             abort_done
);

  logic accept;
  logic running;

  ep_abort_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .abort_req  (abort_req),
    .busy_banks (busy_banks),
    .kill_done  (kill_done),
    .accept     (accept),
    .running    (running),
    .kill_stb   (kill_stb),
    .done_stb   (abort_done)
  );

  ep_abort_irqmask u_mask (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .running (running),
    .set_req (irq_en_set),
    .en      (tx_irq_en)
  );

  AST_DONE_MASKED: assert property (@(posedge clk) disable iff (rst)
    abort_done |-> !tx_irq_en);  // R8

endmodule

// File: tb/sim_ep_in_abort.sv
module sim_ep_in_abort;

  localparam int MAXB = 7;
  localparam int CW   = $clog2(MAXB + 1);
  localparam int NVEC = 7;
  // each entry: {busy banks at start [7:4], kill-complete delay [3:0]}
  localparam logic [7:0] VEC [NVEC] = '{8'h00, 8'h10, 8'h20, 8'h31, 8'h43, 8'h70, 8'h52};

  logic clk = 1'b0;
  logic rst, abort_req, irq_en_set, kill_done;
  logic [CW-1:0] busy_banks;
  logic kill_stb, tx_irq_en, abort_done;

  int checks = 0;
  int errors = 0;
  int kills, dones;
  bit ordering_bad;

  always #10 clk = ~clk;

  ep_in_abort #(.MAX_BANKS(MAXB)) u0 (
    .clk(clk), .rst(rst), .abort_req(abort_req), .irq_en_set(irq_en_set),
    .busy_banks(busy_banks), .kill_done(kill_done), .kill_stb(kill_stb),
    .tx_irq_en(tx_irq_en), .abort_done(abort_done)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Acts as the bank logic; when disturb is set, it drives abort_req and
  // irq_en_set on every cycle until done is seen.
  task automatic run_abort(input int busy0, input int dly, input bit disturb);
    int cnt;
    bit pend;
    pend = 0;
    cnt = 0;
    kills = 0;
    dones = 0;
    ordering_bad = 0;
    busy_banks = CW'(busy0);
    abort_req = 1'b1;
    tick();
    abort_req = disturb;
    check("R2 enable masked on accept", tx_irq_en, 0);
    for (int i = 0; i < 300; i++) begin
      kill_done = 1'b0;
      irq_en_set = disturb;
      if (pend && cnt == 0) begin
        kill_done = 1'b1;
        busy_banks = busy_banks - 1'b1;
        pend = 0;
      end else if (pend) begin
        cnt--;
      end
      tick();
      if (kill_stb) begin
        if (pend) ordering_bad = 1;
        kills++;
        pend = 1;
        cnt = dly;
      end
      if (abort_done) begin
        if (pend) ordering_bad = 1;
        dones++;
        break;
      end
    end
    abort_req = 1'b0;
    irq_en_set = 1'b0;
    kill_done = 1'b0;
    if (disturb) check("R8 enable held low during run", tx_irq_en, 0);
    tick();
    check("R6 done is one cycle", abort_done, 0);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    abort_req = 1'b0;
    irq_en_set = 1'b0;
    kill_done = 1'b0;
    busy_banks = '0;
    tick();
    tick();
    check("R1 reset enable", tx_irq_en, 1);
    check("R1 reset kill", kill_stb, 0);
    check("R1 reset done", abort_done, 0);
    rst = 1'b0;
    tick();
    check("R1 idle stays quiet", kill_stb | abort_done, 0);

    // Table of stimulus and expected results
    for (int v = 0; v < NVEC; v++) begin
      run_abort(int'(VEC[v][7:4]), int'(VEC[v][3:0]), 1'b0);
      check("R6 kill count equals busy banks", kills, int'(VEC[v][7:4]));
      check("R6 single done", dones, 1);
      check("R5 no kill or done before kill complete", int'(ordering_bad), 0);
      check("R4 busy drained", int'(busy_banks), 0);
      irq_en_set = 1'b1;
      tick();
      irq_en_set = 1'b0;
      check("R8 set in idle", tx_irq_en, 1);
    end

    // R3: zero busy gives done exactly two edges after the request, with no kill
    busy_banks = '0;
    abort_req = 1'b1;
    tick();
    abort_req = 1'b0;
    check("R3 no done after first edge", abort_done, 0);
    check("R3 no kill after first edge", kill_stb, 0);
    tick();
    check("R3 done after second edge", abort_done, 1);
    check("R3 no kill with zero busy", kill_stb, 0);
    tick();

    // R4 and R5: exact kill timing, then re-evaluation after kill_done
    busy_banks = CW'(1);
    abort_req = 1'b1;
    tick();
    abort_req = 1'b0;
    tick();
    check("R4 kill after evaluation", kill_stb, 1);
    tick();
    check("R4 kill is one cycle", kill_stb, 0);
    tick();
    tick();
    check("R5 waiting without kill_done", kill_stb | abort_done, 0);
    kill_done = 1'b1;
    busy_banks = '0;
    tick();
    kill_done = 1'b0;
    check("R5 no done on kill_done edge", abort_done, 0);
    tick();
    check("R5 done after re-evaluation", abort_done, 1);
    tick();

    // R7 and R8: abort and set held high through a running sequence
    run_abort(3, 2, 1'b1);
    check("R7 extra requests ignored, kills", kills, 3);
    check("R7 extra requests ignored, dones", dones, 1);
    check("R7 block idle after sequence", kill_stb | abort_done, 0);

    // R8: set and accepted abort in the same cycle; the abort wins
    irq_en_set = 1'b1;
    tick();
    irq_en_set = 1'b0;
    check("R8 enable set before collision", tx_irq_en, 1);
    busy_banks = '0;
    abort_req = 1'b1;
    irq_en_set = 1'b1;
    tick();
    abort_req = 1'b0;
    irq_en_set = 1'b0;
    check("R8 abort wins over set", tx_irq_en, 0);
    tick();
    check("R8 collision sequence done", abort_done, 1);
    tick();

    // R9: kill_done in idle does nothing
    irq_en_set = 1'b1;
    tick();
    irq_en_set = 1'b0;
    busy_banks = CW'(2);
    kill_done = 1'b1;
    tick();
    tick();
    kill_done = 1'b0;
    tick();
    check("R9 stray kill_done gives no kill", kill_stb, 0);
    check("R9 stray kill_done gives no done", abort_done, 0);
    check("R9 stray kill_done keeps enable", tx_irq_en, 1);

    // R6: a new request is accepted after the previous sequence
    run_abort(2, 0, 1'b0);
    check("R6 new sequence accepted", kills, 2);
    check("R6 new sequence done", dones, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule